// File: doc/BRIEF.md
# Oversampled Bit Phase Tracker

This block recovers serial bits from a line that is sampled at five evenly spaced phases inside every period of a local clock. That clock is not locked to the incoming data and may run a little fast or slow against it. Every cycle the block receives a fresh vector of five samples. It keeps the vector from the cycle before, so it can look for rising data edges across a ten-sample window. The position of an edge tells it which sample phase lies nearest the middle of a bit.

A five-state phase machine (states 0 to 4, reset value 2) holds the chosen centre phase. It follows the detected edges by at most one step per cycle. When it wraps between the last and the first phase, the local clock has gained or lost a whole bit against the line. The block then delivers zero or two bits in that cycle, and one bit in every other cycle. Its outputs are a count of 0, 1 or 2 and two data bits. A deserializer downstream consumes these to build characters.

Top module: `bit_phase_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase state is set to 2 and the outputs become count 1, first 0, second 0 at that edge.
- R2: The window is the previous vector (phases 0..4 as window bits 0..4) followed by the current vector (window bits 5..9). A rising edge at alignment k means window bits k..k+2 are low and bits k+3..k+5 are high. Such an edge, for k in 0..4, nominates phase k as the bit centre.
- R3: The state moves toward a nominated phase by exactly one step per cycle. It steps up (modulo 5) when the phase lies 1 or 2 steps above the state, and steps down when it lies 3 or 4 steps above. It holds when the nominated phase equals the state. If several phases are nominated, the one nearest the state wins, checking offsets in the order 0, +1, -1, +2, -2.
- R4: In a cycle with no nominated phase, the state holds.
- R5: From reset, the state reaches any of the five phases within three rising edges.
- R6: Outputs are registered and refer to the previous vector. In a cycle without a wrap, the count is 1, first is the previous vector's sample at the new state's phase, and second is 0.
- R7: When the state wraps from 4 to 0, the count is 0 in that cycle.
- R8: When the state wraps from 0 to 4, the count is 2. First is the previous vector's phase-0 sample and second is its phase-4 sample.
- R9: The count is never 3. For a stream whose bit period lies within 2% of five sample intervals, once the block has locked it delivers every line bit exactly once and in order.
- R10: Data slower than the local clock produces only zero-bit cycles. Faster data produces only two-bit cycles. Data at the exact rate produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_i | input | 5 | Line samples of this cycle, bit p taken at phase p (earliest is 0) |
| bit_cnt_o | output | 2 | Number of valid recovered bits this cycle: 0, 1 or 2 |
| bit_first_o | output | 1 | Earlier recovered bit |
| bit_second_o | output | 1 | Later recovered bit, valid only when the count is 2 |

## Verification
Some rules are checked by the assertions on every cycle. The count never reaches 3. The phase state only moves to a neighbour. It holds whenever the edge window nominates nothing, and it moves whenever an edge nominates a different phase. A zero or two count appears only together with the matching wrap of the state. Other behaviour needs the bench's scenarios to show it. These are the exact phase picked after each edge, the step direction for offsets of two, and the order of the two bits in a double cycle, all observed through probe vectors. They also include lock speed and bit-exact recovery with the right slip direction on drifting streams.

// File: rtl/bpt_pkg.sv
// Shared types for the bit phase tracker.
// Assumes the count output is two bits wide and takes only the values 0..2.
package bpt_pkg;
    typedef logic [1:0] bitcnt_t;

    localparam bitcnt_t CNT_ZERO = 2'd0;
    localparam bitcnt_t CNT_ONE  = 2'd1;
    localparam bitcnt_t CNT_TWO  = 2'd2;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_UP,
        STEP_DOWN
    } step_e;
endpackage

// File: rtl/bpt_edge_window.sv
// Holds the previous sample vector and looks for rising data edges across
// the window formed by the previous and current vectors. Each edge alignment
// nominates one centre phase.
// Assumes 2*RUN_LEN <= N_PHASE + 1, so every alignment fits in the window.
module bpt_edge_window #(
    parameter int N_PHASE = 5,
    parameter int RUN_LEN = 3,
    parameter int CTR_OFS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] samp_i,
    output logic [N_PHASE-1:0] prev_o,
    output logic [N_PHASE-1:0] nom_o
);
    localparam int WIN = 2 * N_PHASE;

    logic [N_PHASE-1:0] prev_q;
    logic [WIN-1:0]     win;

    // Keep the last vector so the window spans two cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= samp_i;
    end

    // Window bits in time order: older vector first.
    assign win    = {samp_i, prev_q};
    assign prev_o = prev_q;

    // One low-run/high-run matcher per alignment; the centre phase it names.
    for (genvar k = 0; k < N_PHASE; k++) begin : g_align
        localparam int CPH = (k + RUN_LEN + CTR_OFS) % N_PHASE;
        assign nom_o[CPH] = (win[k +: RUN_LEN] == '0) &&
                            (win[k + RUN_LEN +: RUN_LEN] == '1);
    end
endmodule

// File: rtl/bpt_phase_fsm.sv
// Circular phase state machine. Picks the nominated phase nearest to the
// current state, then steps one position toward it. Flags wraps between the
// last and first phase.
// Assumes at most one state change per cycle is wanted, to filter jitter.
module bpt_phase_fsm
    import bpt_pkg::*;
#(
    parameter int N_PHASE = 5,
    localparam int PW     = $clog2(N_PHASE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] nom_i,
    output logic [PW-1:0]      state_o,
    output logic [PW-1:0]      next_o,
    output logic               slip_zero_o,
    output logic               slip_two_o
);
    localparam logic [PW-1:0] PH_MID  = PW'(N_PHASE / 2);
    localparam logic [PW-1:0] PH_LAST = PW'(N_PHASE - 1);

    logic [PW-1:0] state_q;
    logic [PW-1:0] state_d;
    logic          found;
    int            ofs;
    step_e         dir;

    // Nearest nominated phase: offsets 0, +1, -1, +2, -2 ...
    always_comb begin
        found = 1'b0;
        ofs   = 0;
        for (int d = 0; d <= N_PHASE / 2; d++) begin
            if (!found && nom_i[PW'((int'(state_q) + d) % N_PHASE)]) begin
                found = 1'b1;
                ofs   = d;
            end
            if (!found && d != 0 &&
                nom_i[PW'((int'(state_q) + N_PHASE - d) % N_PHASE)]) begin
                found = 1'b1;
                ofs   = N_PHASE - d;
            end
        end
    end

    // Direction of the single step toward the chosen phase.
    always_comb begin
        if (!found || ofs == 0)     dir = STEP_HOLD;
        else if (ofs <= N_PHASE / 2) dir = STEP_UP;
        else                         dir = STEP_DOWN;
    end

    // Next state, wrapping around the phase circle.
    always_comb begin
        unique case (dir)
            STEP_UP:   state_d = (state_q == PH_LAST) ? '0 : state_q + 1'b1;
            STEP_DOWN: state_d = (state_q == '0) ? PH_LAST : state_q - 1'b1;
            default:   state_d = state_q;
        endcase
    end

    // Phase state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_MID;
        else        state_q <= state_d;
    end

    assign state_o     = state_q;
    assign next_o      = state_d;
    assign slip_zero_o = (state_q == PH_LAST) && (state_d == '0);
    assign slip_two_o  = (state_q == '0) && (state_d == PH_LAST);
endmodule

// File: rtl/bpt_bit_select.sv
// Registers the recovered bits and their count from the previous vector,
// using the phase the state machine moves to in this cycle.
// Assumes the two slip flags are never raised together.
module bpt_bit_select
    import bpt_pkg::*;
#(
    parameter int N_PHASE = 5,
    localparam int PW     = $clog2(N_PHASE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] prev_i,
    input  logic [PW-1:0]      next_i,
    input  logic               slip_zero_i,
    input  logic               slip_two_i,
    output bitcnt_t            cnt_o,
    output logic               first_o,
    output logic               second_o
);
    // Output register: zero, one or two bits per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o    <= CNT_ONE;
            first_o  <= 1'b0;
            second_o <= 1'b0;
        end else if (slip_zero_i) begin
            cnt_o    <= CNT_ZERO;
            first_o  <= 1'b0;
            second_o <= 1'b0;
        end else if (slip_two_i) begin
            cnt_o    <= CNT_TWO;
            first_o  <= prev_i[0];
            second_o <= prev_i[N_PHASE-1];
        end else begin
            cnt_o    <= CNT_ONE;
            first_o  <= prev_i[next_i];
            second_o <= 1'b0;
        end
    end
endmodule

// File: rtl/bit_phase_tracker.sv
// Top of the oversampled bit phase tracker. Joins the edge window, the
// phase state machine and the output selector.
// Assumes samp_i bit p is the sample taken at phase p of this clock period.
module bit_phase_tracker
    import bpt_pkg::*;
#(
    parameter int N_PHASE = 5,
    parameter int RUN_LEN = 3,
    parameter int CTR_OFS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] samp_i,
    output logic [1:0]         bit_cnt_o,
    output logic               bit_first_o,
    output logic               bit_second_o
);
    localparam int PW = $clog2(N_PHASE);

    logic [N_PHASE-1:0] prev_vec;
    logic [N_PHASE-1:0] nominate;
    logic [PW-1:0]      phase_q;
    logic [PW-1:0]      phase_d;
    logic               slip_zero;
    logic               slip_two;
    bitcnt_t            cnt;

    bpt_edge_window #(
        .N_PHASE(N_PHASE), .RUN_LEN(RUN_LEN), .CTR_OFS(CTR_OFS)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_i),
        .prev_o(prev_vec), .nom_o(nominate)
    );

    bpt_phase_fsm #(.N_PHASE(N_PHASE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .nom_i(nominate),
        .state_o(phase_q), .next_o(phase_d),
        .slip_zero_o(slip_zero), .slip_two_o(slip_two)
    );

    bpt_bit_select #(.N_PHASE(N_PHASE)) u_sel (
        .clk(clk), .rst_n(rst_n), .prev_i(prev_vec), .next_i(phase_d),
        .slip_zero_i(slip_zero), .slip_two_i(slip_two),
        .cnt_o(cnt), .first_o(bit_first_o), .second_o(bit_second_o)
    );

    assign bit_cnt_o = cnt;
endmodule

// File: rtl/bpt_checker.sv
// Property checker for the bit phase tracker, bound to the top module.
// Watches the count output, the phase state and the nominated phases.
module bpt_checker #(
    parameter int N_PHASE = 5,
    localparam int PW     = $clog2(N_PHASE)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         cnt,
    input logic [PW-1:0]      state,
    input logic [N_PHASE-1:0] nom
);
    localparam logic [PW-1:0] PH_MID  = PW'(N_PHASE / 2);
    localparam logic [PW-1:0] PH_LAST = PW'(N_PHASE - 1);

    logic armed_q = 1'b0;

    // Set once the previous edge was already out of reset.
    always_ff @(posedge clk) armed_q <= rst_n;

    function automatic logic [PW-1:0] ph_up(input logic [PW-1:0] p);
        return (p == PH_LAST) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ph_dn(input logic [PW-1:0] p);
        return (p == '0) ? PH_LAST : p - 1'b1;
    endfunction

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state == PH_MID && cnt == 2'd1));

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);

    // R3
    adjacent_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (state == $past(state) || state == ph_up($past(state)) ||
                     state == ph_dn($past(state))));

    // R4
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nom == '0) |=> $stable(state));

    // R3
    follow_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nom != '0 && !nom[state]) |=> (state != $past(state)));

    // R7
    zero_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cnt == 2'd0) |-> (state == '0 && $past(state) == PH_LAST));

    // R8
    two_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cnt == 2'd2) |-> (state == PH_LAST && $past(state) == '0));
endmodule

bind bit_phase_tracker bpt_checker #(.N_PHASE(N_PHASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(bit_cnt_o), .state(phase_q), .nom(nominate)
);

// File: tb/bit_phase_tracker_tb.sv
// Bench: directed probes of the phase state, then a table of drifting
// line scenarios checked for bit-exact recovery and slip direction.
module bit_phase_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPH        = 5;
    localparam int NCYC       = 1200;
    localparam int NSCN       = 4;
    // Bit period = NUM/DEN sample intervals; OFF shifts the start phase.
    localparam int SCN_NUM [NSCN] = '{50, 50, 49, 51};
    localparam int SCN_DEN [NSCN] = '{10, 10, 10, 10};
    localparam int SCN_OFF [NSCN] = '{0, 23, 7, 31};
    // Expected slip kind: 0 none, 1 zero-bit cycles only, 2 two-bit only.
    localparam int SCN_SLIP[NSCN] = '{0, 0, 2, 1};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NPH-1:0] samp = '0;
    logic [1:0]     cnt;
    logic           f_bit;
    logic           s_bit;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  tx   [0:2047];
    bit  rx   [0:4095];

    bit_phase_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .samp_i(samp),
        .bit_cnt_o(cnt), .bit_first_o(f_bit), .bit_second_o(s_bit)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Drive one vector away from the edge, then sample just after the edge.
    task automatic step(input logic [NPH-1:0] v);
        @(negedge clk);
        samp = v;
        @(posedge clk);
        #1;
    endtask

    // Read the state through the outputs: five vectors each with one low
    // phase and no rising edge; the low sample that comes out names the state.
    task automatic probe(output int st, output bit cnt_bad);
        int zc;
        zc = 0;
        st = 7;
        cnt_bad = 1'b0;
        for (int p = 0; p <= NPH; p++) begin
            if (p < NPH) step(5'(~(5'd1 << p)));
            else         step(5'h1F);
            if (p >= 1) begin
                if (cnt != 2'd1) cnt_bad = 1'b1;
                if (!f_bit) begin
                    zc++;
                    st = p - 1;
                end
            end
        end
        if (zc != 1) st = 7;
    endtask

    // One rising edge at window alignment k; outputs sampled after it.
    task automatic make_edge(input int k, input bit use_a, input logic [NPH-1:0] a_ovr,
                             output logic [1:0] c, output logic ff, output logic ss);
        logic [NPH-1:0] va;
        logic [NPH-1:0] vb;
        int e;
        e = k + 3;
        if (e >= NPH) begin
            va = '0;
            vb = 5'(5'h1F << (e - NPH));
        end else begin
            va = 5'(5'h1F << e);
            vb = 5'h1F;
        end
        if (use_a) va = a_ovr;
        step('0);
        step(va);
        step(vb);
        c  = cnt;
        ff = f_bit;
        ss = s_bit;
    endtask

    task automatic expect_state(input int exp, input string tag);
        int st;
        bit bad;
        probe(st, bad);
        chk(st == exp, tag, st, exp);
        chk(!bad, "R4 count stays 1 while no edge", int'(bad), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [6:0] lfsr;
        logic [1:0] c;
        logic ff;
        logic ss;

        lfsr = 7'h5B;
        for (int i = 0; i < 2048; i++) begin
            tx[i] = lfsr[6];
            lfsr  = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
        end

        // ---- reset values (R1)
        rst_n = 1'b0;
        step('0);
        step('0);
        chk(cnt == 2'd1, "R1 reset count", cnt, 1);
        chk(f_bit == 1'b0 && s_bit == 1'b0, "R1 reset data bits", {f_bit, s_bit}, 0);
        rst_n = 1'b1;
        step(5'h1F);
        expect_state(2, "R1 reset phase");

        // ---- directed moves of the phase state
        make_edge(2, 1'b0, '0, c, ff, ss);
        expect_state(2, "R3 nominated phase equals state holds");
        make_edge(0, 1'b0, '0, c, ff, ss);
        chk(c == 2'd1 && ff == 1'b0, "R6 single bit count and value", {c, ff}, 2);
        expect_state(1, "R3 one step down for offset -2");
        make_edge(0, 1'b0, '0, c, ff, ss);
        expect_state(0, "R5 phase 0 reached after two edges");
        make_edge(4, 1'b1, 5'b00001, c, ff, ss);
        chk(c == 2'd2, "R8 wrap 0 to 4 count", c, 2);
        chk(ff == 1'b1, "R8 first is phase-0 sample", ff, 1);
        chk(ss == 1'b0, "R8 second is phase-4 sample", ss, 0);
        expect_state(4, "R2 alignment 4 nominates phase 4");
        make_edge(0, 1'b0, '0, c, ff, ss);
        chk(c == 2'd0, "R7 wrap 4 to 0 count", c, 0);
        expect_state(0, "R2 alignment 0 nominates phase 0");
        make_edge(2, 1'b0, '0, c, ff, ss);
        expect_state(1, "R3 offset +2 steps up");
        make_edge(4, 1'b0, '0, c, ff, ss);
        expect_state(0, "R3 offset -2 steps down");
        expect_state(0, "R4 no edge keeps phase");

        // ---- reset in mid-run, then lock upward
        rst_n = 1'b0;
        step('0);
        chk(cnt == 2'd1 && f_bit == 1'b0, "R1 mid-run reset outputs", {cnt, f_bit}, 2);
        rst_n = 1'b1;
        step(5'h1F);
        expect_state(2, "R1 mid-run reset phase");
        make_edge(4, 1'b0, '0, c, ff, ss);
        expect_state(3, "R5 first edge toward phase 4");
        make_edge(4, 1'b0, '0, c, ff, ss);
        expect_state(4, "R5 phase 4 reached after two edges");

        // ---- drifting line scenarios (R9, R10)
        for (int sc = 0; sc < NSCN; sc++) begin
            int nrx, n0, n2, j0, last_idx, bad_i;
            nrx = 0;
            n0 = 0;
            n2 = 0;
            last_idx = 0;
            rst_n = 1'b0;
            step('0);
            step('0);
            rst_n = 1'b1;
            for (int cy = 0; cy < NCYC; cy++) begin
                logic [NPH-1:0] v;
                for (int p = 0; p < NPH; p++) begin
                    int g;
                    g = cy * NPH + p;
                    last_idx = (g * SCN_DEN[sc] + SCN_OFF[sc]) / SCN_NUM[sc];
                    v[p] = tx[last_idx];
                end
                step(v);
                chk(cnt != 2'd3, "R9 count never 3", cnt, 2);
                if (cy >= 12) begin
                    if (cnt == 2'd0) n0++;
                    if (cnt == 2'd2) n2++;
                    if (cnt != 2'd0) begin
                        rx[nrx] = f_bit;
                        nrx++;
                    end
                    if (cnt == 2'd2) begin
                        rx[nrx] = s_bit;
                        nrx++;
                    end
                end
            end
            // Find where the recovered stream sits in the line stream.
            j0 = -1;
            for (int j = 0; j < 40 && j0 < 0; j++) begin
                bit ok;
                ok = 1'b1;
                for (int i = 0; i < 48; i++) if (rx[i] != tx[j + i]) ok = 1'b0;
                if (ok) j0 = j;
            end
            bad_i = -1;
            if (j0 >= 0) begin
                for (int i = 0; i < nrx; i++)
                    if (bad_i < 0 && j0 + i < last_idx - 2 && rx[i] != tx[j0 + i])
                        bad_i = i;
            end
            chk(j0 >= 0 && bad_i < 0, $sformatf("R9 bit-exact recovery scenario %0d", sc),
                (j0 < 0) ? -1 : bad_i, -1);
            chk(nrx + j0 >= last_idx - 16 && nrx + j0 <= last_idx,
                $sformatf("R9 no bit lost or repeated scenario %0d", sc), nrx + j0, last_idx);
            if (SCN_SLIP[sc] == 0)
                chk(n0 == 0 && n2 == 0, $sformatf("R10 no slip scenario %0d", sc), n0 + n2, 0);
            else if (SCN_SLIP[sc] == 1)
                chk(n0 > 0 && n2 == 0, $sformatf("R10 slow data zero-bit cycles scenario %0d", sc),
                    n2, 0);
            else
                chk(n2 > 0 && n0 == 0, $sformatf("R10 fast data two-bit cycles scenario %0d", sc),
                    n0, 0);
        end

        finish_run();
    end
endmodule